// File: doc/BRIEF.md
# Audio Serial Clock Divider

This block turns a master audio clock into the timing for an audio serial port. It runs entirely on the master clock. A first counter divides that clock down to a bit clock. Two further counters, one for transmit and one for receive, divide the bit clock down to a frame (word-select) clock. Every ratio comes from an 8-bit field that holds the ratio minus one. With a master clock at 256 times the sample rate, a bit ratio of 4 (field 3) and frame ratios of 64 (field 63) give a 64-bit stereo frame. Each frame clock is low for the first half of its frame (left channel) and high for the second half.

Alongside the clock pins, the block gives the serializers single-cycle enables: one for the bit-drive edge, one for the bit-sample edge, and one per direction that marks the first bit of a frame. When the role input selects slave operation, the local counters stop. The enables are then recovered from externally supplied bit and frame clocks through a two-stage synchronizer, and the clock outputs are released. A polarity input inverts the bit clock. A run input holds every counter at its start point while transfers are stopped.

Top module: `audio_clk_div`

## Requirements
- R1: In master mode with run high, the bit clock has a period of `mclk_div_m1`+1 master cycles (field value at least 1). Within each bit period it is low for the first H = (`mclk_div_m1`+1)/2 (rounded down) cycles and high for the rest, starting low in the first cycle run is high.
- R2: `bit_drive_stb` is high for one cycle in the first low cycle of each bit period. `bit_sample_stb` is high for one cycle in the first high cycle. The two are never high together.
- R3: The transmit frame clock has a period of `tx_frame_m1`+1 bit periods (field at least 1). It is low for the first (`tx_frame_m1`+1)/2 bits (rounded down) and high for the rest. `tx_frame_stb` is high together with `bit_drive_stb` in bit 0 of each frame, while the frame clock is low.
- R4: The receive frame clock and `rx_frame_stb` follow the rule of R3, using `rx_frame_m1` and their own counter, independently of the transmit side.
- R5: A change of `mclk_div_m1` or `tx_frame_m1` while running takes effect at the next transmit frame boundary. A change of `rx_frame_m1` takes effect at the next receive frame boundary. Before the boundary the old ratios stay in force.
- R6: While run is low, the counters stay at their start point. The bit clock sits at its idle level (low before inversion), both frame clocks are low and no strobe fires. When run goes high, bit 0 of frame 0 begins in that same cycle.
- R7: With `bclk_inv` high, `bclk_out` is the inverse of the R1 waveform. The strobes and frame clocks are unaffected.
- R8: With `slave_mode` high (1 = slave, 0 = master), `clk_oe` is low and all three clock outputs are low. With run high, a rising edge of `ext_bclk` XOR `bclk_inv` gives `bit_sample_stb` and a falling edge gives `bit_drive_stb`. A falling edge of `ext_tx_fs` gives `tx_frame_stb` and a falling edge of `ext_rx_fs` gives `rx_frame_stb`. Each strobe lasts one cycle and is high in the cycle after the second rising clock edge that samples the new level.
- R9: Synchronous active-high reset clears all counters. After reset, with run low and `bclk_inv` low, every output except `clk_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Transfers active; low holds the dividers at their start point |
| slave_mode | input | 1 | 0 = generate clocks locally, 1 = use external clocks |
| bclk_inv | input | 1 | Inverts the bit clock |
| mclk_div_m1 | input | 8 | Master-to-bit-clock ratio minus one |
| tx_frame_m1 | input | 8 | Bits per transmit frame minus one |
| rx_frame_m1 | input | 8 | Bits per receive frame minus one |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_tx_fs | input | 1 | External transmit frame clock (slave mode) |
| ext_rx_fs | input | 1 | External receive frame clock (slave mode) |
| clk_oe | output | 1 | High when the clock outputs are driven (master mode) |
| bclk_out | output | 1 | Bit clock output |
| tx_fs_out | output | 1 | Transmit frame clock output |
| rx_fs_out | output | 1 | Receive frame clock output |
| bit_drive_stb | output | 1 | One-cycle enable at the bit-drive edge |
| bit_sample_stb | output | 1 | One-cycle enable at the bit-sample edge |
| tx_frame_stb | output | 1 | One-cycle enable at the start of a transmit frame |
| rx_frame_stb | output | 1 | One-cycle enable at the start of a receive frame |

## Verification
The assertions assume that every ratio field holds at least 1, so that each period has a low and a high half. They also assume that `bclk_inv` and `slave_mode` change only while run is low, and that external clocks hold each level for at least three master cycles. The stimulus sweeps field values from 1 upward and changes polarity and role only between runs with run low. It changes ratios mid-run only to test R5, and it holds external pin levels for several cycles before each strobe is sampled.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    // Role select: bit value matches the slave_mode input
    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } clk_role_e;

    // Serializer enables for one bit period
    typedef struct packed {
        logic drive;
        logic sample;
    } bit_stb_t;

    // Number of low cycles / low bits for a ratio stored as ratio minus one
    function automatic int unsigned low_span(input int unsigned ratio_m1);
        return (ratio_m1 + 1) / 2;
    endfunction

endpackage

// File: rtl/aclk_bit_div.sv
module aclk_bit_div
    import aclk_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         reload,
    input  logic [W-1:0] ratio_m1,
    output logic         bclk_lvl,
    output bit_stb_t     stb,
    output logic         bit_last
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] m1_q;
    logic [W-1:0] half;
    logic [W-1:0] cnt_inc;
    logic         bclk_q;

    assign half     = W'(low_span(int'(m1_q)));
    assign cnt_inc  = cnt_q + 1'b1;
    assign bit_last = en && (cnt_q == m1_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            m1_q   <= '0;
            bclk_q <= 1'b0;
        end else begin
            if (reload) begin
                m1_q <= ratio_m1;
            end
            if (!en || bit_last) begin
                cnt_q  <= '0;
                bclk_q <= 1'b0;
            end else begin
                cnt_q  <= cnt_inc;
                bclk_q <= (cnt_inc >= half);
            end
        end
    end

    assign bclk_lvl   = bclk_q;
    assign stb.drive  = en && (cnt_q == '0);
    assign stb.sample = en && (cnt_q == half);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb.drive, stb.sample}));

    // R2
    sample_high_chk: assert property (@(posedge clk) disable iff (rst)
        stb.sample |-> bclk_q);

    // R5
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(m1_q));

endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div
    import aclk_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         bit_last,
    input  logic         bit_drive,
    input  logic [W-1:0] ratio_m1,
    output logic         fs_lvl,
    output logic         frame_stb,
    output logic         frame_last
);

    logic [W-1:0] bcnt_q;
    logic [W-1:0] f_q;
    logic [W-1:0] half;
    logic [W-1:0] bcnt_inc;
    logic         fs_q;
    logic         reload;

    assign half       = W'(low_span(int'(f_q)));
    assign bcnt_inc   = bcnt_q + 1'b1;
    assign frame_last = bit_last && (bcnt_q == f_q);
    assign reload     = !en || frame_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_q <= '0;
            f_q    <= '0;
            fs_q   <= 1'b0;
        end else begin
            if (reload) begin
                f_q <= ratio_m1;
            end
            if (!en || frame_last) begin
                bcnt_q <= '0;
                fs_q   <= 1'b0;
            end else if (bit_last) begin
                bcnt_q <= bcnt_inc;
                fs_q   <= (bcnt_inc >= half);
            end
        end
    end

    assign fs_lvl    = fs_q;
    assign frame_stb = bit_drive && (bcnt_q == '0);

    // R3
    frame_low_chk: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> !fs_q);

    // R3
    fs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fs_q) |-> $past(bit_last || !en));

    // R5
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(f_q));

endmodule

// File: rtl/aclk_ext_edge.sv
module aclk_ext_edge #(
    parameter int unsigned LANES = 3,
    parameter int unsigned SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] pin,
    output logic [LANES-1:0] rise,
    output logic [LANES-1:0] fall
);

    localparam int unsigned DEPTH = SYNC + 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [DEPTH-1:0] sh_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q <= '0;
            end else begin
                sh_q <= {sh_q[DEPTH-2:0], pin[i]};
            end
        end

        assign rise[i] =  sh_q[SYNC-1] && !sh_q[SYNC];
        assign fall[i] = !sh_q[SYNC-1] &&  sh_q[SYNC];

        // R8
        rise_single_chk: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);

        // R8
        fall_single_chk: assert property (@(posedge clk) disable iff (rst)
            fall[i] |=> !fall[i]);
    end

endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
    import aclk_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             slave_mode,
    input  logic             bclk_inv,
    input  logic [DIV_W-1:0] mclk_div_m1,
    input  logic [DIV_W-1:0] tx_frame_m1,
    input  logic [DIV_W-1:0] rx_frame_m1,
    input  logic             ext_bclk,
    input  logic             ext_tx_fs,
    input  logic             ext_rx_fs,
    output logic             clk_oe,
    output logic             bclk_out,
    output logic             tx_fs_out,
    output logic             rx_fs_out,
    output logic             bit_drive_stb,
    output logic             bit_sample_stb,
    output logic             tx_frame_stb,
    output logic             rx_frame_stb
);

    localparam int unsigned LANE_BCLK = 0;
    localparam int unsigned LANE_TXFS = 1;
    localparam int unsigned LANE_RXFS = 2;
    localparam int unsigned N_LANES   = 3;

    clk_role_e role;
    logic      m_act;
    logic      s_act;

    assign role  = clk_role_e'(slave_mode);
    assign m_act = run && (role == ROLE_MASTER);
    assign s_act = run && (role == ROLE_SLAVE);

    bit_stb_t bstb;
    logic     bclk_lvl;
    logic     bit_last;
    logic     tx_fs, rx_fs;
    logic     tx_stb, rx_stb;
    logic     tx_last, rx_last;

    aclk_bit_div #(.W(DIV_W)) u_bit (
        .clk      (clk),
        .rst      (rst),
        .en       (m_act),
        .reload   (!m_act || tx_last),
        .ratio_m1 (mclk_div_m1),
        .bclk_lvl (bclk_lvl),
        .stb      (bstb),
        .bit_last (bit_last)
    );

    aclk_frame_div #(.W(DIV_W)) u_tx_frame (
        .clk        (clk),
        .rst        (rst),
        .en         (m_act),
        .bit_last   (bit_last),
        .bit_drive  (bstb.drive),
        .ratio_m1   (tx_frame_m1),
        .fs_lvl     (tx_fs),
        .frame_stb  (tx_stb),
        .frame_last (tx_last)
    );

    aclk_frame_div #(.W(DIV_W)) u_rx_frame (
        .clk        (clk),
        .rst        (rst),
        .en         (m_act),
        .bit_last   (bit_last),
        .bit_drive  (bstb.drive),
        .ratio_m1   (rx_frame_m1),
        .fs_lvl     (rx_fs),
        .frame_stb  (rx_stb),
        .frame_last (rx_last)
    );

    logic [N_LANES-1:0] ext_pins;
    logic [N_LANES-1:0] ext_rise;
    logic [N_LANES-1:0] ext_fall;

    assign ext_pins[LANE_BCLK] = ext_bclk ^ bclk_inv;
    assign ext_pins[LANE_TXFS] = ext_tx_fs;
    assign ext_pins[LANE_RXFS] = ext_rx_fs;

    aclk_ext_edge #(.LANES(N_LANES), .SYNC(2)) u_ext (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_pins),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    always_comb begin
        if (role == ROLE_MASTER) begin
            clk_oe         = 1'b1;
            bclk_out       = bclk_lvl ^ bclk_inv;
            tx_fs_out      = tx_fs;
            rx_fs_out      = rx_fs;
            bit_drive_stb  = bstb.drive;
            bit_sample_stb = bstb.sample;
            tx_frame_stb   = tx_stb;
            rx_frame_stb   = rx_stb;
        end else begin
            clk_oe         = 1'b0;
            bclk_out       = 1'b0;
            tx_fs_out      = 1'b0;
            rx_fs_out      = 1'b0;
            bit_drive_stb  = s_act && ext_fall[LANE_BCLK];
            bit_sample_stb = s_act && ext_rise[LANE_BCLK];
            tx_frame_stb   = s_act && ext_fall[LANE_TXFS];
            rx_frame_stb   = s_act && ext_fall[LANE_RXFS];
        end
    end

    // R1
    sample_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (m_act && bit_sample_stb) |-> (bclk_out != $past(bclk_out)));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && $past(!run)) |-> (!tx_fs_out && !rx_fs_out && (bclk_out == bclk_inv || slave_mode)));

    // R3
    tx_frame_on_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (m_act && tx_frame_stb) |-> bit_drive_stb);

endmodule

// File: tb/audio_clk_div_tb.sv
module audio_clk_div_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       slave_mode = 1'b0;
    logic       bclk_inv = 1'b0;
    logic [7:0] mclk_div_m1 = 8'd3;
    logic [7:0] tx_frame_m1 = 8'd3;
    logic [7:0] rx_frame_m1 = 8'd3;
    logic       ext_bclk = 1'b0;
    logic       ext_tx_fs = 1'b0;
    logic       ext_rx_fs = 1'b0;
    logic       clk_oe, bclk_out, tx_fs_out, rx_fs_out;
    logic       bit_drive_stb, bit_sample_stb, tx_frame_stb, rx_frame_stb;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    audio_clk_div u_dut (
        .clk(clk), .rst(rst), .run(run), .slave_mode(slave_mode), .bclk_inv(bclk_inv),
        .mclk_div_m1(mclk_div_m1), .tx_frame_m1(tx_frame_m1), .rx_frame_m1(rx_frame_m1),
        .ext_bclk(ext_bclk), .ext_tx_fs(ext_tx_fs), .ext_rx_fs(ext_rx_fs),
        .clk_oe(clk_oe), .bclk_out(bclk_out), .tx_fs_out(tx_fs_out), .rx_fs_out(rx_fs_out),
        .bit_drive_stb(bit_drive_stb), .bit_sample_stb(bit_sample_stb),
        .tx_frame_stb(tx_frame_stb), .rx_frame_stb(rx_frame_stb)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected bit-clock group {bclk, drive, sample} at cycle k
    function automatic int exp_bit(int m, int inv, int k);
        int n = m + 1;
        int h = n / 2;
        int mc = k % n;
        return ((((mc >= h) ? 1 : 0) ^ inv) << 2) | ((mc == 0) << 1) | (mc == h);
    endfunction

    // Expected frame group {fs, stb} at cycle k
    function automatic int exp_frm(int m, int f, int k);
        int n = m + 1;
        int mc = k % n;
        int b = (k / n) % (f + 1);
        return (((b >= (f + 1) / 2) ? 1 : 0) << 1) | ((mc == 0 && b == 0) ? 1 : 0);
    endfunction

    task automatic stop_and_idle(input int inv);
        @(negedge clk);
        run = 1'b0;
        bclk_inv = inv[0];
        @(negedge clk);
        @(negedge clk);
    endtask

    // Steady run of one configuration; one check per output group
    task automatic sweep_cfg(input int m, input int t, input int r, input int inv, input int cycles);
        int bad_b = 0, bad_t = 0, bad_r = 0;
        int ab = 0, eb = 0, at = 0, et = 0, ar = 0, er = 0;
        string tag;
        stop_and_idle(inv);
        mclk_div_m1 = 8'(m); tx_frame_m1 = 8'(t); rx_frame_m1 = 8'(r);
        @(negedge clk);
        run = 1'b1;
        for (int k = 0; k < cycles; k++) begin
            int gb, gt, gr, xb, xt, xr;
            #1;
            gb = {29'd0, bclk_out, bit_drive_stb, bit_sample_stb};
            gt = {30'd0, tx_fs_out, tx_frame_stb};
            gr = {30'd0, rx_fs_out, rx_frame_stb};
            xb = exp_bit(m, inv, k); xt = exp_frm(m, t, k); xr = exp_frm(m, r, k);
            if (gb != xb && bad_b == 0) begin ab = gb; eb = xb; bad_b = 1; end
            if (gt != xt && bad_t == 0) begin at = gt; et = xt; bad_t = 1; end
            if (gr != xr && bad_r == 0) begin ar = gr; er = xr; bad_r = 1; end
            @(negedge clk);
        end
        tag = $sformatf("m=%0d t=%0d r=%0d inv=%0d", m, t, r, inv);
        chk(inv ? "R1/R2/R7" : "R1/R2", {"bit clock ", tag}, ab, eb);
        chk("R3", {"tx frame ", tag}, at, et);
        chk("R4", {"rx frame ", tag}, ar, er);
        run = 1'b0;
    endtask

    // Ratio change mid-run: new values from cycle c, expected in force from off_tx / off_rx
    task automatic change_test(input string req, input int m0, input int t0, input int r0,
                               input int m1, input int t1, input int r1,
                               input int c, input int off_tx, input int off_rx, input int cycles);
        int bad = 0, a = 0, e = 0;
        stop_and_idle(0);
        mclk_div_m1 = 8'(m0); tx_frame_m1 = 8'(t0); rx_frame_m1 = 8'(r0);
        @(negedge clk);
        run = 1'b1;
        for (int k = 0; k < cycles; k++) begin
            int g, x, mt, kt, kr, rr;
            if (k == c) begin
                mclk_div_m1 = 8'(m1); tx_frame_m1 = 8'(t1); rx_frame_m1 = 8'(r1);
            end
            #1;
            mt = (k < off_tx) ? m0 : m1;
            kt = (k < off_tx) ? k : k - off_tx;
            kr = (k < off_rx) ? k : k - off_rx;
            rr = (k < off_rx) ? r0 : r1;
            g = {25'd0, bclk_out, bit_drive_stb, bit_sample_stb, tx_fs_out, tx_frame_stb,
                 rx_fs_out, rx_frame_stb};
            x = (exp_bit(mt, 0, kt) << 4) | (exp_frm(mt, (k < off_tx) ? t0 : t1, kt) << 2)
                | exp_frm(mt, rr, kr);
            if (g != x && bad == 0) begin a = g; e = x; bad = 1; end
            @(negedge clk);
        end
        chk(req, "ratio change at frame boundary", a, e);
        run = 1'b0;
    endtask

    task automatic slave_edge(input string req, input string what, input int lane, input int lvl,
                              input int exp_drv, input int exp_smp, input int exp_tx, input int exp_rx);
        int g;
        @(negedge clk);
        case (lane)
            0: ext_bclk = lvl[0];
            1: ext_tx_fs = lvl[0];
            default: ext_rx_fs = lvl[0];
        endcase
        @(negedge clk);
        chk(req, {what, " not early"},
            {28'd0, bit_drive_stb, bit_sample_stb, tx_frame_stb, rx_frame_stb}, 0);
        @(negedge clk);
        g = {28'd0, bit_drive_stb, bit_sample_stb, tx_frame_stb, rx_frame_stb};
        chk(req, what, g, (exp_drv << 3) | (exp_smp << 2) | (exp_tx << 1) | exp_rx);
        @(negedge clk);
        chk(req, {what, " one cycle"},
            {28'd0, bit_drive_stb, bit_sample_stb, tx_frame_stb, rx_frame_stb}, 0);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int ts[5] = '{1, 2, 3, 4, 7};
        int rs[5] = '{2, 1, 5, 3, 2};
        int quiet;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset state
        chk("R9", "outputs after reset",
            {24'd0, clk_oe, bclk_out, tx_fs_out, rx_fs_out, bit_drive_stb, bit_sample_stb,
             tx_frame_stb, rx_frame_stb}, 8'h80);

        // R6: stopped, both polarities
        for (int inv = 0; inv < 2; inv++) begin
            stop_and_idle(inv);
            quiet = 1;
            for (int k = 0; k < 20; k++) begin
                #1;
                if (bit_drive_stb || bit_sample_stb || tx_frame_stb || rx_frame_stb ||
                    tx_fs_out || rx_fs_out || bclk_out != inv[0]) quiet = 0;
                @(negedge clk);
            end
            chk("R6", $sformatf("idle while stopped inv=%0d", inv), quiet, 1);
        end

        // R1 R2 R3 R4 R6 R7: sweep of small ratios
        for (int m = 1; m <= 4; m++) begin
            for (int j = 0; j < 5; j++) begin
                sweep_cfg(m, ts[j], rs[j], (m + j) % 2,
                          (m + 1) * (ts[j] + 1) * (rs[j] + 1) + 2 * (m + 1));
            end
        end
        // R3 R4: intended 64-bit frame with ratio 4
        sweep_cfg(3, 63, 63, 0, 4 * 64 * 2 + 8);

        // R5: all ratios change mid-frame; tx and rx frames equal so boundaries coincide
        change_test("R5", 3, 3, 3, 1, 1, 1, 5, 16, 16, 40);
        // R5: only rx ratio changes; rx boundary at 4 cycles (2 bits of 2 cycles)
        change_test("R5", 1, 3, 1, 1, 3, 3, 1, 1 << 20, 4, 40);

        // R8: slave mode
        stop_and_idle(0);
        slave_mode = 1'b1;
        ext_bclk = 1'b0; ext_tx_fs = 1'b1; ext_rx_fs = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk("R8", "outputs released in slave", {29'd0, clk_oe, bclk_out, tx_fs_out}, 0);
        // R8: stopped slave ignores edges
        slave_edge("R8", "stopped slave bclk rise", 0, 1, 0, 0, 0, 0);
        slave_edge("R8", "stopped slave bclk fall", 0, 0, 0, 0, 0, 0);
        run = 1'b1;
        slave_edge("R8", "ext bclk rise", 0, 1, 0, 1, 0, 0);
        slave_edge("R8", "ext bclk fall", 0, 0, 1, 0, 0, 0);
        slave_edge("R8", "ext tx fs fall", 1, 0, 0, 0, 1, 0);
        slave_edge("R8", "ext tx fs rise", 1, 1, 0, 0, 0, 0);
        slave_edge("R8", "ext rx fs fall", 2, 0, 0, 0, 0, 1);
        // R8 R7: inverted polarity swaps the bit edges
        @(negedge clk);
        run = 1'b0;
        bclk_inv = 1'b1;
        repeat (4) @(negedge clk);
        run = 1'b1;
        slave_edge("R8", "inverted ext bclk rise", 0, 1, 1, 0, 0, 0);
        chk("R8", "bclk out low in slave", {31'd0, bclk_out}, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule